// File: doc/BRIEF.md
# Toggle-Mask Interrupt Controller

This block gathers sixteen peripheral interrupt request lines into a sticky status register and gates them with a mask register to form one interrupt output toward the processor. A request line sets its status bit on each rising edge. The bit stays set until software clears it by writing a one to that position. The interrupt output is high whenever at least one status bit is set and its mask bit is also set.

The mask has an unusual write rule. A write does not replace the mask: every one in the write data flips the matching mask bit. Software that wants to enable or disable a line therefore has to know the current mask value, or read it first.

A second, cascaded group of two request lines from a secondary bus sets bits in a separate flag register. These bits sit at the sparse positions 8 and 10, and software clears them by writing ones. While any of these flags is set, they act as a request on primary line 1. Software reaches all three registers through a simple register bus. Writes take effect on the clock edge, and reads are combinational and have no side effects.

Top module: `irq_toggle_ctrl`

## Requirements
- R1: After reset, the status, mask and flag registers all read zero and `cpu_irq` is low.
- R2: A rising edge on `req_i[k]` sets status bit k at the next clock edge. If a line stays high after its bit has been cleared, the bit does not set again until the line falls and rises again.
- R3: `cpu_irq` is high exactly when (status AND mask) is nonzero. Since the mask resets to zero, no line raises `cpu_irq` until it has been unmasked.
- R4: A write to address 0xF000 clears every status bit whose bit in `reg_wdata[15:0]` is 1. All other status bits are left unchanged.
- R5: A write to address 0xF010 XORs `reg_wdata[15:0]` into the mask. Each 1 flips its mask bit and each 0 leaves its mask bit unchanged.
- R6: A rising edge on `sec_req_i[0]` sets flag bit 8, and a rising edge on `sec_req_i[1]` sets flag bit 10. The flag register reads at address 0xF230, and every other bit in that word reads 0.
- R7: A write to address 0xF230 clears each flag bit (8 or 10) that is 1 in the write data. The other flag bit is left unchanged.
- R8: While any flag bit is set, it acts as a request on primary line 1. When the flags go from all-zero to nonzero, status bit 1 sets one clock edge after the flag itself sets.
- R9: Reading a register does not change it.
- R10: If a rising request edge and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R11: A write to any address other than the three register addresses changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 16 | Peripheral request lines, edge-detected |
| sec_req_i | input | 2 | Secondary-bus request lines, edge-detected |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| cpu_irq | output | 1 | Interrupt output to the processor |

## Verification
A rising request edge and a software write-one-clear can land on the same status bit in the same cycle. The bench provokes this by raising `req_i[3]` at the same falling edge where it drives a clear of bit 3 to address 0xF000. It then reads the status at a later negative edge and expects bit 3 set, because a set must win over a clear. A related case also runs: a clear while a line is still held high must stick, and the bit must set again only after the line falls and rises.

// File: rtl/irq_toggle_ctrl.sv
module irq_toggle_ctrl #(
  parameter int NREQ      = 16,
  parameter int NSEC      = 2,
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int SEC_BASE  = 8,
  parameter int SEC_STEP  = 2,
  parameter int CASC_LINE = 1,
  parameter logic [AW-1:0] STAT_ADDR = 16'hF000,
  parameter logic [AW-1:0] MASK_ADDR = 16'hF010,
  parameter logic [AW-1:0] FLAG_ADDR = 16'hF230
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_i,
  input  logic [NSEC-1:0] sec_req_i,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            cpu_irq
);
  logic [NREQ-1:0] status_q, mask_q, req_q, req_eff, req_rise, stat_clr;
  logic [NSEC-1:0] flag_q, sec_q, sec_rise, flag_clr;
  logic [DW-1:0]   flag_word;
  logic            wr_stat, wr_mask, wr_flag;

  assign wr_stat = reg_wr && (reg_addr == STAT_ADDR);
  assign wr_mask = reg_wr && (reg_addr == MASK_ADDR);
  assign wr_flag = reg_wr && (reg_addr == FLAG_ADDR);

  always_comb begin
    req_eff = req_i;
    req_eff[CASC_LINE] = req_i[CASC_LINE] | (|flag_q);
  end

  assign req_rise = req_eff & ~req_q;
  assign sec_rise = sec_req_i & ~sec_q;
  assign stat_clr = wr_stat ? reg_wdata[NREQ-1:0] : '0;

  always_comb begin
    flag_word = '0;
    flag_clr  = '0;
    for (int i = 0; i < NSEC; i++) begin
      flag_word[SEC_BASE + SEC_STEP*i] = flag_q[i];
      flag_clr[i] = wr_flag & reg_wdata[SEC_BASE + SEC_STEP*i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      req_q    <= '0;
      flag_q   <= '0;
      sec_q    <= '0;
    end else begin
      req_q    <= req_eff;
      sec_q    <= sec_req_i;
      status_q <= (status_q & ~stat_clr) | req_rise;
      flag_q   <= (flag_q & ~flag_clr) | sec_rise;
      if (wr_mask)
        mask_q <= mask_q ^ reg_wdata[NREQ-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      STAT_ADDR: reg_rdata[NREQ-1:0] = status_q;
      MASK_ADDR: reg_rdata[NREQ-1:0] = mask_q;
      FLAG_ADDR: reg_rdata = flag_word;
      default:   reg_rdata = '0;
    endcase
  end

  assign cpu_irq = |(status_q & mask_q);
endmodule

// File: rtl/irq_toggle_ctrl_chk.sv
module irq_toggle_ctrl_chk #(
  parameter int NREQ = 16,
  parameter int NSEC = 2,
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter logic [AW-1:0] STAT_ADDR = 16'hF000,
  parameter logic [AW-1:0] MASK_ADDR = 16'hF010
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req_i,
  input logic            reg_wr,
  input logic [AW-1:0]   reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic [NREQ-1:0] status,
  input logic [NREQ-1:0] mask,
  input logic [NSEC-1:0] flags,
  input logic            cpu_irq
);
  logic [NREQ-1:0] prev_req;
  always_ff @(posedge clk) prev_req <= rst_n ? req_i : '1;

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (status == '0 && mask == '0 && flags == '0));

  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !cpu_irq);

  a_r5_mask_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == MASK_ADDR) |=> mask == ($past(mask) ^ $past(reg_wdata[NREQ-1:0])));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == STAT_ADDR && req_i == '0 && flags == '0)
      |=> (status & $past(reg_wdata[NREQ-1:0])) == '0);

  a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status & $past(req_i & ~prev_req)) == $past(req_i & ~prev_req));
endmodule

bind irq_toggle_ctrl irq_toggle_ctrl_chk #(
  .NREQ(NREQ), .NSEC(NSEC), .AW(AW), .DW(DW),
  .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .status(status_q),
  .mask(mask_q), .flags(flag_q), .cpu_irq(cpu_irq)
);

// File: tb/irq_toggle_ctrl_tb.sv
module irq_toggle_ctrl_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] req_i = '0;
  logic [1:0]  sec_req_i = '0;
  logic        reg_wr = 0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_irq;
  int total = 0, bad = 0;

  localparam logic [15:0] A_ST = 16'hF000, A_MK = 16'hF010, A_FL = 16'hF230;

  always #2 clk = ~clk;

  irq_toggle_ctrl dut_i (.clk, .rst_n, .req_i, .sec_req_i, .reg_wr,
    .reg_addr, .reg_wdata, .reg_rdata, .cpu_irq);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 0;
  endtask

  task automatic set_req(logic [15:0] r);
    @(negedge clk);
    req_i = r;
    @(posedge clk);
  endtask

  task automatic irq_chk(string tag, logic exp);
    @(negedge clk);
    chk(tag, {31'b0, cpu_irq}, {31'b0, exp});
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_ST, v); chk("R1 status", v, 0);
    rd(A_MK, v); chk("R1 mask", v, 0);
    rd(A_FL, v); chk("R1 flags", v, 0);
    irq_chk("R1 irq", 0);
  endtask

  task automatic t_edge_mask;
    logic [31:0] v;
    set_req(16'h0020);
    rd(A_ST, v); chk("R2 edge sets bit5", v, 32'h20);
    irq_chk("R3 masked stays low", 0);
    wr(A_MK, 32'h0020);
    rd(A_MK, v); chk("R5 toggle on", v, 32'h20);
    irq_chk("R3 unmasked high", 1);
    wr(A_MK, 32'h0021);
    rd(A_MK, v); chk("R5 toggle xor", v, 32'h01);
    irq_chk("R3 masked again", 0);
    wr(A_MK, 32'h0020);
    rd(A_MK, v); chk("R5 toggle back", v, 32'h21);
  endtask

  task automatic t_clear_held;
    logic [31:0] v;
    wr(A_ST, 32'h0020);
    rd(A_ST, v); chk("R4 clear while held", v, 0);
    irq_chk("R3 drop after clear", 0);
    repeat (3) @(posedge clk);
    rd(A_ST, v); chk("R2 held no reset", v, 0);
    set_req(16'h0000);
    set_req(16'hA020);
    rd(A_ST, v); chk("R2 re-edge", v, 32'hA020);
    wr(A_ST, 32'h8000);
    rd(A_ST, v); chk("R4 partial clear", v, 32'h2020);
    rd(A_ST, v); chk("R9 read no side effect", v, 32'h2020);
    wr(A_ST, 32'hFFFF);
    set_req(16'h0000);
    rd(A_ST, v); chk("R4 all clear", v, 0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] v;
    @(negedge clk);
    req_i = 16'h0008; reg_wr = 1; reg_addr = A_ST; reg_wdata = 32'h0008;
    @(posedge clk);
    #1 reg_wr = 0;
    rd(A_ST, v); chk("R10 set beats clear", v, 32'h0008);
    set_req(16'h0000);
    wr(A_ST, 32'h0008);
  endtask

  task automatic t_other_addr;
    logic [31:0] v, m;
    set_req(16'h0004);
    rd(A_MK, m);
    wr(16'hF020, 32'hFFFF_FFFF);
    wr(16'h0000, 32'hFFFF_FFFF);
    rd(A_ST, v); chk("R11 status kept", v, 32'h0004);
    rd(A_MK, v); chk("R11 mask kept", v, m);
    rd(16'hF020, v); chk("R11 unmapped reads 0", v, 0);
    set_req(16'h0000);
    wr(A_ST, 32'h0004);
  endtask

  task automatic t_secondary;
    logic [31:0] v;
    @(negedge clk);
    sec_req_i = 2'b01;
    @(posedge clk);
    #1 v = 0;
    reg_addr = A_FL;
    #0.5 chk("R6 sec0 sets bit8", reg_rdata, 32'h100);
    reg_addr = A_ST;
    #0.5 chk("R8 status1 not yet", reg_rdata, 0);
    @(posedge clk);
    rd(A_ST, v); chk("R8 cascade sets bit1", v, 32'h2);
    set_req(16'h0000);
    @(negedge clk); sec_req_i = 2'b11;
    rd(A_FL, v); chk("R6 sec1 sets bit10", v, 32'h500);
    wr(A_MK, 32'h0002);
    irq_chk("R3 cascade irq", 1);
    wr(A_FL, 32'h0000_0100);
    rd(A_FL, v); chk("R7 clear bit8 only", v, 32'h400);
    wr(A_FL, 32'h0000_0400);
    rd(A_FL, v); chk("R7 clear bit10", v, 0);
    rd(A_ST, v); chk("R8 status bit sticky", v, 32'h2);
    wr(A_ST, 32'h0002);
    irq_chk("R3 cascade cleared", 0);
    @(negedge clk); sec_req_i = 2'b00;
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_edge_mask();
    t_clear_held();
    t_same_cycle();
    t_other_addr();
    t_secondary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule